// File: doc/BRIEF.md
# Run-Length Bit Stream Expander

This block turns a stream of 8-bit run-length code bytes into a serial stream of single bits, one bit per output handshake, for a downstream configuration shifter. Each code byte describes one run. A code can be a run of ones closed by a zero, a run of ones left open, or a run of zeros closed by a one. The longest run of ones that one code can carry is the compile-time parameter `MAX_ONES`, which must lie between 1 and 252.

Code bytes arrive on a valid/ready input and are expanded strictly in arrival order. A new byte is taken only after every bit of the previous one has been handed off. The value 255 marks the end of the stream and produces a one-cycle pulse. The value 0 is not a legal code: it produces no bits and raises a sticky error flag, and decoding carries on with the bytes that follow. Output bits obey backpressure, so a bit is retired only once the consumer has taken it.

Top module: `rle_bit_expander`

## Requirements
- R1: A code n with 1 <= n <= MAX_ONES produces n one-bits followed by exactly one zero-bit.
- R2: The code MAX_ONES+1 produces MAX_ONES one-bits and no closing zero-bit.
- R3: A code n with MAX_ONES+2 <= n <= 254 produces n-(MAX_ONES+2) zero-bits followed by exactly one one-bit. The code MAX_ONES+2 therefore produces a single one-bit.
- R4: The code 255 produces no output bits. `end_of_stream_o` is high for exactly the one cycle after the code is accepted and low otherwise.
- R5: The code 0 produces no output bits and sets `bad_code_o`. The flag stays high until reset, and later codes are still expanded normally.
- R6: `in_ready_o` is high only when no bit of the current code is still waiting. `in_ready_o` and `out_valid_o` are never high in the same cycle, and codes are expanded in the order they were accepted.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_bit_o` does not change in the next cycle. No bit is lost or repeated under backpressure.
- R8: While `rst_ni` is low, and directly after it is released, `out_valid_o`, `end_of_stream_o` and `bad_code_o` are 0 and `in_ready_o` is 1. Reset abandons a run that is being expanded.
- R9: The first bit of an accepted code is presented on `out_valid_o`/`out_bit_o` in the cycle right after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | A code byte is offered |
| in_code_i | input | 8 | Code byte |
| in_ready_o | output | 1 | Expander can take a code byte |
| out_valid_o | output | 1 | An output bit is offered |
| out_ready_i | input | 1 | Consumer takes the offered bit |
| out_bit_o | output | 1 | Serial output bit |
| end_of_stream_o | output | 1 | One-cycle pulse after the end code is accepted |
| bad_code_o | output | 1 | Sticky flag: an illegal zero code was seen |

## Verification
The bench builds the block with `MAX_ONES` = 6. With this value every closed ones-run is short, the open-run code is 7, and the zero-run range runs from 8 up to 254. Both ends of every code range can then be reached in a short run. This includes the empty zero run (code 8) and the longest zero run of 246 zeros (code 254), which also serves as a long expansion that reset can cut off partway through.

// File: rtl/rle_pkg.sv
`timescale 1ns/1ps
package rle_pkg;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] END_CODE = '1;

  typedef enum logic [2:0] {
    KIND_INVALID,
    KIND_ONES_TERM,
    KIND_ONES_OPEN,
    KIND_ZEROS_TERM,
    KIND_END
  } code_kind_e;
endpackage

// File: rtl/rle_code_decode.sv
`timescale 1ns/1ps
module rle_code_decode
  import rle_pkg::*;
#(
  parameter int MAX_ONES = 100
) (
  input  logic [CODE_W-1:0] code_i,
  output code_kind_e        kind_o,
  output logic [CODE_W-1:0] len_o,
  output logic              run_val_o,
  output logic              term_en_o
);
  localparam logic [CODE_W-1:0] OnesMax  = CODE_W'(MAX_ONES);
  localparam logic [CODE_W-1:0] OpenCode = CODE_W'(MAX_ONES + 1);
  localparam logic [CODE_W-1:0] ZeroBase = CODE_W'(MAX_ONES + 2);

  // Range classification; a closing bit is always the opposite of the run value.
  always_comb begin
    kind_o    = KIND_INVALID;
    len_o     = '0;
    run_val_o = 1'b0;
    term_en_o = 1'b0;
    if (code_i == '0) begin
      kind_o = KIND_INVALID;
    end else if (code_i <= OnesMax) begin
      kind_o    = KIND_ONES_TERM;
      len_o     = code_i;
      run_val_o = 1'b1;
      term_en_o = 1'b1;
    end else if (code_i == OpenCode) begin
      kind_o    = KIND_ONES_OPEN;
      len_o     = OnesMax;
      run_val_o = 1'b1;
      term_en_o = 1'b0;
    end else if (code_i == END_CODE) begin
      kind_o = KIND_END;
    end else begin
      kind_o    = KIND_ZEROS_TERM;
      len_o     = code_i - ZeroBase;
      run_val_o = 1'b0;
      term_en_o = 1'b1;
    end
  end
endmodule

// File: rtl/rle_run_engine.sv
`timescale 1ns/1ps
module rle_run_engine #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_val_i,
  input  logic             term_en_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic             out_bit_o,
  output logic             idle_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             val_q, val_d;
  logic             run_left;
  logic             fire;
  logic             en;

  always_comb begin
    run_left    = (cnt_q != '0);
    out_valid_o = run_left | pend_q;
    out_bit_o   = run_left ? val_q : ~val_q;
    idle_o      = ~out_valid_o;
    fire        = out_valid_o & out_ready_i;
    en          = load_i | fire;
  end

  // Next state: load a fresh run, or retire one bit (run bits first, then the closing bit).
  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    val_d  = val_q;
    if (load_i) begin
      cnt_d  = len_i;
      pend_d = term_en_i;
      val_d  = run_val_i;
    end else if (fire) begin
      if (run_left) begin
        cnt_d = cnt_q - 1'b1;
      end else begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      val_q  <= 1'b0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      val_q  <= val_d;
    end
  end

  // R7: an offered bit that is not taken stays offered and unchanged
  a_r7_hold_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_bit_o)));

  // R6: a new run is only loaded once the previous one has fully drained
  a_r6_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> idle_o);
endmodule

// File: rtl/rle_stream_flags.sv
`timescale 1ns/1ps
module rle_stream_flags
  import rle_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  code_kind_e kind_i,
  output logic       eos_o,
  output logic       bad_o
);
  logic eos_hit, bad_hit;
  logic eos_d, bad_d;
  logic eos_en, bad_en;

  always_comb begin
    eos_hit = accept_i && (kind_i == KIND_END);
    bad_hit = accept_i && (kind_i == KIND_INVALID);
    eos_d   = eos_hit;
    bad_d   = 1'b1;
    eos_en  = eos_o | eos_hit;
    bad_en  = bad_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eos_o <= 1'b0;
    end else if (eos_en) begin
      eos_o <= eos_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_o <= 1'b0;
    end else if (bad_en) begin
      bad_o <= bad_d;
    end
  end

  // R5: the error flag never clears outside reset
  a_r5_bad_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> bad_o);
endmodule

// File: rtl/rle_bit_expander.sv
`timescale 1ns/1ps
module rle_bit_expander
  import rle_pkg::*;
#(
  parameter int MAX_ONES = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [CODE_W-1:0] in_code_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_bit_o,
  output logic              end_of_stream_o,
  output logic              bad_code_o
);
  localparam logic [CODE_W-1:0] OnesMaxC  = CODE_W'(MAX_ONES);
  localparam logic [CODE_W-1:0] ZeroBaseC = CODE_W'(MAX_ONES + 2);

  code_kind_e        dec_kind;
  logic [CODE_W-1:0] dec_len;
  logic              dec_run_val;
  logic              dec_term_en;
  logic              eng_idle;
  logic              accept;
  logic              load;

  rle_code_decode #(.MAX_ONES(MAX_ONES)) u_decode (
    .code_i    (in_code_i),
    .kind_o    (dec_kind),
    .len_o     (dec_len),
    .run_val_o (dec_run_val),
    .term_en_o (dec_term_en)
  );

  always_comb begin
    in_ready_o = eng_idle;
    accept     = in_valid_i & in_ready_o;
    load       = accept && (dec_kind inside {KIND_ONES_TERM, KIND_ONES_OPEN, KIND_ZEROS_TERM});
  end

  rle_run_engine #(.CNT_W(CODE_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .len_i       (dec_len),
    .run_val_i   (dec_run_val),
    .term_en_i   (dec_term_en),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_bit_o   (out_bit_o),
    .idle_o      (eng_idle)
  );

  rle_stream_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .kind_i   (dec_kind),
    .eos_o    (end_of_stream_o),
    .bad_o    (bad_code_o)
  );

  // R6: input and output sides never handshake-capable together
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  // R4: end pulse follows an accepted end code, and nothing else
  a_r4_eos_follows_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_code_i == END_CODE) |=> end_of_stream_o);
  a_r4_eos_only_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept && in_code_i == END_CODE) |=> !end_of_stream_o);

  // R1 / R9: a closed ones-run presents a one in the next cycle
  a_r1_first_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_code_i != '0 && in_code_i <= OnesMaxC) |=> (out_valid_o && out_bit_o));

  // R3: the empty zero run presents its closing one at once
  a_r3_empty_zero_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_code_i == ZeroBaseC) |=> (out_valid_o && out_bit_o));

  // R5: an illegal code leaves the expander ready with no bit offered
  a_r5_bad_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_code_i == '0) |=> (in_ready_o && !out_valid_o && bad_code_o));
endmodule

// File: tb/sim_rle_bit_expander.sv
`timescale 1ns/1ps
module sim_rle_bit_expander;
  localparam int M = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_code = '0;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_bit;
  logic       eos;
  logic       bad;

  always #10 clk = ~clk;

  rle_bit_expander #(.MAX_ONES(M)) u0 (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .in_valid_i      (in_valid),
    .in_code_i       (in_code),
    .in_ready_o      (in_ready),
    .out_valid_o     (out_valid),
    .out_ready_i     (out_ready),
    .out_bit_o       (out_bit),
    .end_of_stream_o (eos),
    .bad_code_o      (bad)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit exp_q[$];
  bit got_q[$];
  int code_q[$];
  bit stall_en = 1'b0;
  int cyc = 0;
  int hold_viol = 0;
  int stall_seen = 0;
  bit hold_pend = 1'b0;
  bit hold_bit = 1'b0;

  // Output collector: drives ready and records accepted bits, away from the rising edge.
  always @(negedge clk) begin
    cyc++;
    if (hold_pend) begin
      if (!out_valid || out_bit != hold_bit) hold_viol++;
      hold_pend = 1'b0;
    end
    out_ready = !stall_en || (cyc % 3 != 0);
    if (out_valid && out_ready) got_q.push_back(out_bit);
    if (out_valid && !out_ready) begin
      hold_pend = 1'b1;
      hold_bit  = out_bit;
      stall_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic add_exp(input int c);
    if (c >= 1 && c <= M) begin
      repeat (c) exp_q.push_back(1'b1);
      exp_q.push_back(1'b0);
    end else if (c == M + 1) begin
      repeat (M) exp_q.push_back(1'b1);
    end else if (c >= M + 2 && c <= 254) begin
      repeat (c - (M + 2)) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the accepting rising edge.
  task automatic put(input int c);
    in_code  = 8'(c);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_codes(input string req);
    int t;
    int mism;
    exp_q.delete();
    got_q.delete();
    foreach (code_q[i]) add_exp(code_q[i]);
    foreach (code_q[i]) put(code_q[i]);
    t = 0;
    while (got_q.size() < exp_q.size() && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, "bit count", got_q.size(), exp_q.size());
    mism = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
      if (mism < 0 && got_q[i] != exp_q[i]) mism = i;
    end
    chk(mism < 0, req, "first mismatching bit index", mism, -1);
  endtask

  task automatic t_reset_state;
    chk(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
    chk(eos == 1'b0 && bad == 1'b0, "R8", "flags in reset", {eos, bad}, 0);
  endtask

  task automatic t_closed_ones;
    code_q = {1, M, 3};
    run_codes("R1");
  endtask

  task automatic t_open_ones;
    code_q = {M + 1, 2, M + 1};
    run_codes("R2");
  endtask

  task automatic t_zero_runs;
    code_q = {M + 2, M + 3, 254, M + 2};
    run_codes("R3");
  endtask

  task automatic t_end_code;
    exp_q.delete();
    got_q.delete();
    put(255);
    chk(eos == 1'b1, "R4", "eos the cycle after accept", eos, 1);
    chk(out_valid == 1'b0, "R4", "no bit for end code", out_valid, 0);
    @(negedge clk);
    chk(eos == 1'b0, "R4", "eos one cycle only", eos, 0);
    repeat (3) @(negedge clk);
    chk(got_q.size() == 0, "R4", "bits emitted", got_q.size(), 0);
  endtask

  task automatic t_bad_code;
    got_q.delete();
    put(0);
    chk(bad == 1'b1, "R5", "bad flag set", bad, 1);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R5", "no bit for zero code", out_valid, 0);
    code_q = {2, M + 3};
    run_codes("R5");
    chk(bad == 1'b1, "R5", "bad flag sticky", bad, 1);
  endtask

  task automatic t_latency_order;
    got_q.delete();
    put(3);
    chk(out_valid == 1'b1 && out_bit == 1'b1, "R9", "first bit next cycle", {out_valid, out_bit}, 3);
    chk(in_ready == 1'b0, "R6", "ready low while expanding", in_ready, 0);
    repeat (8) @(negedge clk);
    chk(in_ready == 1'b1, "R6", "ready back after drain", in_ready, 1);
    chk(got_q.size() == 4, "R6", "bits drained", got_q.size(), 4);
  endtask

  task automatic t_backpressure;
    stall_en = 1'b1;
    hold_viol = 0;
    stall_seen = 0;
    code_q = {4, M + 1, M + 4, 1, M + 2, 5};
    run_codes("R7");
    chk(stall_seen > 0, "R7", "stall cycles seen", stall_seen, 1);
    chk(hold_viol == 0, "R7", "bit changed while stalled", hold_viol, 0);
    stall_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_midrun;
    put(0);
    put(254);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R8", "run abandoned by reset", out_valid, 0);
    chk(bad == 1'b0, "R8", "bad flag cleared by reset", bad, 0);
    rst_n = 1'b1;
    @(negedge clk);
    code_q = {2};
    run_codes("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_closed_ones();
    t_open_ones();
    t_zero_runs();
    t_end_code();
    t_bad_code();
    t_latency_order();
    t_backpressure();
    t_reset_midrun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule